// File: doc/BRIEF.md
# Write-Completion Poller for a Parallel EEPROM

This block sits on the host side of a byte-wide parallel EEPROM bus. Once the host has finished the last byte or page load, it hands the poller the address and value of that final byte together with a polling method. The poller then runs back-to-back read cycles on the memory bus to learn that the internal programming cycle has ended. Without it, the host would have to wait out the worst-case write time.

Two methods are offered. In data-polling mode, the most significant data bit reads back inverted while programming is in progress, so completion is the first read whose bit 7 matches bit 7 of the saved byte. In toggle mode, bit 6 flips on every read while programming runs, so completion is the first read whose bit 6 equals bit 6 of the read just before it.

All bus timing is counted in clock cycles:
- a guard interval with output enable high before the first read;
- an access window that covers both the address/chip-enable access time and the output-enable access time;
- an idle gap between reads;
- a hold-off after the result, during which no further write may be started.

A timeout is flagged if completion is not seen within a bounded number of cycles.

Top module: `wcp_poller`

## Requirements
- R1: After reset, chip enable and output enable are high (inactive), busy and both result pulses are low, and write_ok is high.
- R2: A start request that arrives while the block is busy is ignored: the address on the bus and the reference bit used for completion remain those of the accepted request.
- R3: After a start is accepted, chip enable and output enable stay high for GUARD_CYC cycles. The first read then begins, so chip enable first goes low GUARD_CYC cycles after the accepting edge.
- R4: During a read, chip enable and output enable are both low for exactly max(ADDR_ACC_CYC, OE_ACC_CYC) cycles, and the address equals the saved address. The data bus is sampled at the edge that ends this window.
- R5: Between two reads, chip enable and output enable are both high for GAP_CYC cycles, so consecutive reads start ACCESS+GAP cycles apart.
- R6: In data-polling mode (mode_i = 0), completion is the first read whose bit 7 equals bit 7 of the saved data. done_o is then high for exactly one cycle, in the cycle after the sampling edge.
- R7: In toggle mode (mode_i = 1), completion is the first read whose bit 6 equals bit 6 of the previous read in the same run. The first read of a run can never complete.
- R8: If no completion has been seen TIMEOUT_CYC cycles after the accepting edge, timeout_o pulses for one cycle. A completion sampled on that same edge wins and yields done_o instead.
- R9: After done_o or timeout_o, the bus stays idle and busy stays high for NEXT_WR_CYC cycles. Only then do busy fall and write_ok rise.
- R10: done_o and timeout_o are never high together, and each run yields exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin polling; taken only when idle |
| mode_i | input | 1 | 0 = data polling on bit 7, 1 = toggle polling on bit 6 |
| last_addr_i | input | 17 | Address of the last byte written |
| last_data_i | input | 8 | Value of the last byte written |
| bus_data_i | input | 8 | Data bus as driven by the memory |
| ce_n_o | output | 1 | Chip enable to the memory, active low |
| oe_n_o | output | 1 | Output enable to the memory, active low |
| addr_o | output | 17 | Address bus to the memory |
| busy_o | output | 1 | High from acceptance until the post-result hold-off ends |
| done_o | output | 1 | One-cycle pulse: the write cycle has completed |
| timeout_o | output | 1 | One-cycle pulse: no completion inside the limit |
| write_ok_o | output | 1 | High when a new write may be issued |

## Verification
In toggle mode, the device model ends its toggling with bit 6 either equal or unequal to the final true value. A design that compared against the saved data, or that let the first read complete, would report done a read too early. The timeout limit is placed on exactly the edge of a completing sample, and a design that gave the timeout priority would pulse timeout_o instead of done_o. A second start is injected mid-run with the opposite bit 7; a design that re-latched it would finish on the first read and move the address. Read spacing, window length and hold-off length are measured in cycles, so an off-by-one in any phase counter shifts a measured cycle number.

// File: rtl/wcp_pkg.sv
package wcp_pkg;

    parameter int unsigned ADDR_W    = 17;
    parameter int unsigned DATA_W    = 8;
    parameter int unsigned DPOLL_BIT = 7;   // inverted while programming
    parameter int unsigned TPOLL_BIT = 6;   // flips on each read while programming

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GUARD,
        ST_READ,
        ST_GAP,
        ST_HOLD
    } wcp_state_e;

    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_TOGGLE = 1'b1
    } wcp_mode_e;

    typedef struct packed {
        wcp_mode_e           mode;
        logic [ADDR_W-1:0]   addr;
        logic                ref_bit;
    } wcp_job_t;

    function automatic int unsigned cyc_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wcp_span_cnt.sv
module wcp_span_cnt #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic at_limit
);
    localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    assign at_limit = (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && !at_limit) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wcp_detect.sv
module wcp_detect
    import wcp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      smp,
    input  wcp_mode_e mode,
    input  logic      ref_bit,
    input  logic      dpoll_bit,
    input  logic      tpoll_bit,
    output logic      hit
);
    logic prev_ok;
    logic prev_tb;

    always_comb begin
        if (mode == MODE_DATA) begin
            hit = smp && (dpoll_bit == ref_bit);
        end else begin
            hit = smp && prev_ok && (tpoll_bit == prev_tb);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prev_ok <= 1'b0;
            prev_tb <= 1'b0;
        end else if (smp) begin
            prev_ok <= 1'b1;
            prev_tb <= tpoll_bit;
        end
    end
endmodule

// File: rtl/wcp_poller.sv
module wcp_poller
    import wcp_pkg::*;
#(
    parameter int unsigned GUARD_CYC    = 2,
    parameter int unsigned ADDR_ACC_CYC = 15,
    parameter int unsigned OE_ACC_CYC   = 7,
    parameter int unsigned GAP_CYC      = 2,
    parameter int unsigned NEXT_WR_CYC  = 1250,
    parameter int unsigned TIMEOUT_CYC  = 1300000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    input  logic [DATA_W-1:0] last_data_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              ce_n_o,
    output logic              oe_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              write_ok_o
);
    localparam int unsigned READ_CYC = cyc_max(ADDR_ACC_CYC, OE_ACC_CYC);
    localparam int unsigned PH_MAX   =
        cyc_max(cyc_max(GUARD_CYC, READ_CYC), cyc_max(GAP_CYC, NEXT_WR_CYC));
    localparam int unsigned PH_W     = $clog2(PH_MAX + 1);

    wcp_state_e      state, nxt;
    wcp_job_t        job;
    logic [PH_W-1:0] ph_cnt;
    logic [PH_W-1:0] ph_lim;
    logic            ph_end;
    logic            accept, polling, smp, hit, tmo_hit;
    logic            fin_done, fin_tmo;

    assign accept  = (state == ST_IDLE) && start_i;
    assign polling = (state == ST_GUARD) || (state == ST_READ) || (state == ST_GAP);

    always_comb begin
        case (state)
            ST_GUARD: ph_lim = PH_W'(GUARD_CYC);
            ST_READ:  ph_lim = PH_W'(READ_CYC);
            ST_GAP:   ph_lim = PH_W'(GAP_CYC);
            ST_HOLD:  ph_lim = PH_W'(NEXT_WR_CYC);
            default:  ph_lim = PH_W'(1);
        endcase
    end
    assign ph_end = (ph_cnt == ph_lim - 1'b1);

    wcp_span_cnt #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .clr      (accept),
        .en       (polling),
        .at_limit (tmo_hit)
    );

    wcp_detect u_det (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .smp       (smp),
        .mode      (job.mode),
        .ref_bit   (job.ref_bit),
        .dpoll_bit (bus_data_i[DPOLL_BIT]),
        .tpoll_bit (bus_data_i[TPOLL_BIT]),
        .hit       (hit)
    );

    always_comb begin
        nxt      = state;
        smp      = 1'b0;
        fin_done = 1'b0;
        fin_tmo  = 1'b0;
        case (state)
            ST_IDLE:  if (start_i) nxt = ST_GUARD;
            ST_GUARD: if (ph_end)  nxt = ST_READ;
            ST_READ:  if (ph_end)  smp = 1'b1;
            ST_GAP:   if (ph_end)  nxt = ST_READ;
            ST_HOLD:  if (ph_end)  nxt = ST_IDLE;
            default:               nxt = ST_IDLE;
        endcase
        if (hit) begin
            fin_done = 1'b1;
            nxt      = ST_HOLD;
        end else if (polling && tmo_hit) begin
            fin_tmo  = 1'b1;
            nxt      = ST_HOLD;
        end else if (smp) begin
            nxt      = ST_GAP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ph_cnt    <= '0;
            job       <= '0;
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            state     <= nxt;
            ph_cnt    <= (nxt != state) ? '0 : ph_cnt + 1'b1;
            done_o    <= fin_done;
            timeout_o <= fin_tmo;
            if (accept) begin
                job.mode    <= wcp_mode_e'(mode_i);
                job.addr    <= last_addr_i;
                job.ref_bit <= last_data_i[DPOLL_BIT];
            end
        end
    end

    assign ce_n_o     = (state != ST_READ);
    assign oe_n_o     = (state != ST_READ);
    assign addr_o     = job.addr;
    assign busy_o     = (state != ST_IDLE);
    assign write_ok_o = (state == ST_IDLE);
endmodule

// File: rtl/wcp_poller_chk.sv
module wcp_poller_chk
    import wcp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_n_o,
    input logic              oe_n_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              timeout_o,
    input logic              write_ok_o
);
    // R4: output enable is only driven low inside a chip-enabled read
    a_r4_oe_inside_ce: assert property (@(posedge clk) disable iff (rst)
        !oe_n_o |-> !ce_n_o);

    // R4: address held steady across a read
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!ce_n_o && $past(!ce_n_o)) |-> $stable(addr_o));

    // R5: a read ends with both strobes released together
    a_r5_release_both: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_n_o) |-> oe_n_o);

    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: timeout is a single-cycle pulse
    a_r8_tmo_pulse: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

    // R9: a result opens the hold-off, no write allowed yet
    a_r9_hold_after_result: assert property (@(posedge clk) disable iff (rst)
        (done_o || timeout_o) |-> (busy_o && !write_ok_o && ce_n_o));

    // R10: the two results are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done_o && timeout_o));
endmodule

bind wcp_poller wcp_poller_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_n_o     (ce_n_o),
    .oe_n_o     (oe_n_o),
    .addr_o     (addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .timeout_o  (timeout_o),
    .write_ok_o (write_ok_o)
);

// File: tb/wcp_poller_test.sv
module wcp_poller_test;
    import wcp_pkg::*;

    localparam int G  = 2;
    localparam int S  = 15;   // max(15, 7)
    localparam int GP = 2;
    localparam int N  = 20;
    localparam int T  = 357;  // equals the 21st read's sampling edge
    localparam int WDOG = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              mode_i = 1'b0;
    logic [ADDR_W-1:0] last_addr_i = '0;
    logic [DATA_W-1:0] last_data_i = '0;
    logic [DATA_W-1:0] bus_data_i = '0;
    logic              ce_n_o, oe_n_o, busy_o, done_o, timeout_o, write_ok_o;
    logic [ADDR_W-1:0] addr_o;

    always #4 clk = ~clk;   // 125 MHz

    wcp_poller #(
        .GUARD_CYC(G), .ADDR_ACC_CYC(15), .OE_ACC_CYC(7),
        .GAP_CYC(GP), .NEXT_WR_CYC(N), .TIMEOUT_CYC(T)
    ) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .last_addr_i(last_addr_i), .last_data_i(last_data_i),
        .bus_data_i(bus_data_i), .ce_n_o(ce_n_o), .oe_n_o(oe_n_o),
        .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o),
        .timeout_o(timeout_o), .write_ok_o(write_ok_o)
    );

    int checks = 0, fails = 0, total = 0;
    int cyc, rdk, busy_n, done_at, tmo_at, wok_at, nfall, low_run;
    int low_bad, addr_bad, both_bad, done_cnt, tmo_cnt;
    int fall_at[4];
    logic [7:0] dev_d;
    logic [ADDR_W-1:0] exp_addr;
    logic prev_ce;

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: memory model plus monitors, evaluated away from the active edge
    task automatic step();
        @(negedge clk);
        cyc++;
        total++;
        if (total > WDOG) begin
            chk(1'b0, "watchdog", total, WDOG);
            finish_run();
        end
        if (!ce_n_o && prev_ce) begin
            rdk++;
            if (nfall < 4) fall_at[nfall] = cyc;
            nfall++;
        end
        prev_ce = ce_n_o;
        if (!ce_n_o) begin
            if (oe_n_o || addr_o != exp_addr) addr_bad++;
            low_run++;
        end else begin
            if (low_run != 0 && low_run != S) low_bad++;
            low_run = 0;
        end
        if (rdk <= busy_n) bus_data_i = {~dev_d[7], rdk[0], dev_d[5:0]};
        else               bus_data_i = dev_d;
        if (done_o) begin done_cnt++; if (done_at < 0) done_at = cyc; end
        if (timeout_o) begin tmo_cnt++; if (tmo_at < 0) tmo_at = cyc; end
        if (done_o && timeout_o) both_bad++;
        if ((done_at >= 0 || tmo_at >= 0) && write_ok_o && wok_at < 0) wok_at = cyc;
    endtask

    // run one poll; inj >= 0 pulses a competing start at that cycle
    task automatic run_poll(input logic md, input logic [ADDR_W-1:0] a,
                            input logic [7:0] d, input int b, input int inj);
        cyc = 0; rdk = 0; busy_n = b; done_at = -1; tmo_at = -1; wok_at = -1;
        nfall = 0; low_run = 0; low_bad = 0; addr_bad = 0; both_bad = 0;
        done_cnt = 0; tmo_cnt = 0; prev_ce = 1'b1; dev_d = d; exp_addr = a;
        for (int i = 0; i < 4; i++) fall_at[i] = -1;
        mode_i = md; last_addr_i = a; last_data_i = d; start_i = 1'b1;
        step();
        start_i = 1'b0;
        while (wok_at < 0 && cyc < 2000) begin
            if (cyc == inj) begin
                last_addr_i = ~a; last_data_i = ~d; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            step();
        end
        start_i = 1'b0;
    endtask

    function automatic int data_done(input int b);
        return G + (b + 1) * S + b * GP + 1;
    endfunction

    function automatic int toggle_done(input int b, input logic d6);
        int j;
        if (b == 0) j = 2;
        else j = (b[0] == d6) ? b + 1 : b + 2;
        return G + j * S + (j - 1) * GP + 1;
    endfunction

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(ce_n_o === 1'b1 && oe_n_o === 1'b1, "R1 strobes idle", {ce_n_o, oe_n_o}, 3);
        chk(busy_o === 1'b0, "R1 busy low", busy_o, 0);
        chk(done_o === 1'b0 && timeout_o === 1'b0, "R1 results low", {done_o, timeout_o}, 0);
        chk(write_ok_o === 1'b1, "R1 write_ok high", write_ok_o, 1);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_data_timing();
        run_poll(1'b0, 17'h05555, 8'h3C, 2, -1);
        chk(fall_at[0] == G + 1, "R3 first read start", fall_at[0], G + 1);
        chk(fall_at[1] == G + 1 + S + GP, "R5 second read start", fall_at[1], G + 1 + S + GP);
        chk(fall_at[2] == G + 1 + 2 * (S + GP), "R5 third read start", fall_at[2], G + 1 + 2 * (S + GP));
        chk(low_bad == 0, "R4 read window length", low_bad, 0);
        chk(addr_bad == 0, "R4 address and oe during read", addr_bad, 0);
        chk(done_at == data_done(2), "R6 data poll done cycle", done_at, data_done(2));
        chk(done_cnt == 1 && tmo_cnt == 0, "R10 single result", done_cnt, 1);
        chk(wok_at == done_at + N, "R9 hold-off length", wok_at, done_at + N);
    endtask

    task automatic test_data_immediate();
        run_poll(1'b0, 17'h1ABCD, 8'h80, 0, -1);
        chk(done_at == data_done(0), "R6 done on first read", done_at, data_done(0));
        chk(nfall == 1, "R6 one read only", nfall, 1);
    endtask

    task automatic test_toggle();
        run_poll(1'b1, 17'h00123, 8'h00, 0, -1);
        chk(done_at == toggle_done(0, 1'b0), "R7 first read cannot complete", done_at, toggle_done(0, 1'b0));
        run_poll(1'b1, 17'h00456, 8'h40, 3, -1);
        chk(done_at == toggle_done(3, 1'b1), "R7 toggle ends equal", done_at, toggle_done(3, 1'b1));
        run_poll(1'b1, 17'h00789, 8'h80, 3, -1);
        chk(done_at == toggle_done(3, 1'b0), "R7 toggle ends unequal", done_at, toggle_done(3, 1'b0));
        chk(low_bad == 0 && addr_bad == 0, "R4 toggle reads", low_bad + addr_bad, 0);
    endtask

    task automatic test_timeout();
        run_poll(1'b0, 17'h02AAA, 8'h55, 1000, -1);
        chk(tmo_at == T + 1, "R8 timeout cycle", tmo_at, T + 1);
        chk(done_cnt == 0 && tmo_cnt == 1, "R10 timeout only", done_cnt, 0);
        chk(both_bad == 0, "R10 never both", both_bad, 0);
        chk(wok_at == tmo_at + N, "R9 hold-off after timeout", wok_at, tmo_at + N);
        run_poll(1'b0, 17'h02AAB, 8'h55, 20, -1);
        chk(done_at == T + 1 && tmo_at < 0, "R8 completion wins tie", done_at, T + 1);
    endtask

    task automatic test_ignore_start();
        run_poll(1'b0, 17'h0F0F0, 8'h80, 2, 10);
        chk(done_at == data_done(2), "R2 busy start ignored (done)", done_at, data_done(2));
        chk(addr_bad == 0, "R2 busy start ignored (address)", addr_bad, 0);
    endtask

    initial begin
        test_reset();
        test_data_timing();
        test_data_immediate();
        test_toggle();
        test_timeout();
        test_ignore_start();
        finish_run();
    end
endmodule